// File: doc/BRIEF.md
# Addressed Serial Control Register

This block receives control words over a three-line serial bus (data, bit clock and a frame enable) that several devices share. Each frame is 21 bits long. The two leading bits name the device the frame is meant for. When they equal this instance's address, the other 19 bits are loaded into the control outputs. These outputs are a 14-bit divide code, a band select, a 2-bit reference select and two auxiliary bits that drive open-collector pull-downs.

The three bus lines are asynchronous to the system clock. The block resynchronises them and finds their edges in the system clock domain. A frame is committed only when enable falls, and only as a whole. A frame with the wrong length or a foreign address leaves every output as it was, so software on the shared bus can talk to other devices without side effects. The system clock must run at least several times faster than the bus clock, so that every bus edge is seen after resynchronisation.

Top module: `addr3w_ctrl_reg`

## Requirements
- R1: After reset, divide_code is 0, fm_select is 0, ref_select is 0 and pull_dn_n is 2'b11, meaning both pull-downs are off.
- R2: Bits are sampled on rising edges of bus_clk while bus_en is high. The frame starts with the 2 address bits, MSB first, followed by the 14-bit divide code, MSB first, which appears on divide_code.
- R3: Frame bit 17 is the band bit: 1 selects FM (fm_select=1) and 0 selects AM (fm_select=0).
- R4: Frame bits 18 and 19 form ref_select, MSB first.
- R5: Frame bit 20 is auxiliary bit 0 and frame bit 21 is auxiliary bit 1. pull_dn_n[i] is 0 (pulling low) when auxiliary bit i is latched as 1, and 1 otherwise.
- R6: Outputs change only after the falling edge of bus_en. During a frame they keep their previous values.
- R7: A frame whose address differs from parameter DEV_ADDR (default 2'b10) leaves all outputs unchanged.
- R8: A frame with fewer than 21 bits leaves all outputs unchanged.
- R9: A frame with more than 21 bits leaves all outputs unchanged.
- R10: Rising edges of bus_clk while bus_en is low are not counted toward the next frame.
- R11: A later valid frame replaces every field written by an earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bit clock (asynchronous) |
| bus_data | input | 1 | Serial data line |
| bus_en | input | 1 | Frame enable; high while a frame is sent |
| divide_code | output | 14 | Latched divide code |
| fm_select | output | 1 | 1 = FM input selected, 0 = AM |
| ref_select | output | 2 | Latched reference selection |
| pull_dn_n | output | 2 | Active-low pull-down enables for the auxiliary outputs |

## Verification
Valid frames with different bit patterns show that every field lands at its own position. The patterns include all ones, alternating bits, and distinct values in each field, so a shifted or reversed field produces a visible mismatch. Frames carrying a foreign address, 20 bits or 22 bits are sent after a known value has been latched, which separates "rejected" from "loaded something else". Outputs are also sampled in the middle of a frame, to show that nothing changes before enable falls. A burst of bus clock edges with enable low, sent just before a valid frame, shows that the bit count starts fresh at each frame.

// File: rtl/a3w_pkg.sv
package a3w_pkg;
    localparam int A3W_ADDR_W = 2;
    localparam int A3W_CODE_W = 14;
    localparam int A3W_REF_W  = 2;
    localparam int A3W_AUX_W  = 2;

    typedef enum logic {
        BAND_AM = 1'b0,
        BAND_FM = 1'b1
    } band_e;
endpackage

// File: rtl/a3w_sync.sv
module a3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/a3w_shifter.sv
module a3w_shifter #(
    parameter int FRAME_LEN = 21
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_clk,
    input  logic                 s_data,
    input  logic                 s_en,
    output logic [FRAME_LEN-1:0] frame_bits,
    output logic                 frame_end,
    output logic                 frame_ok
);
    localparam int CNT_MAX = FRAME_LEN + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        logic [FRAME_LEN-1:0] sr;
        logic [CNT_W-1:0]     cnt;
        logic                 clk_prev;
        logic                 en_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = s_clk;
        st_d.en_prev  = s_en;
        if (s_en && !st_q.en_prev) begin
            st_d.cnt = '0;
        end else if (s_en && s_clk && !st_q.clk_prev) begin
            st_d.sr = {st_q.sr[FRAME_LEN-2:0], s_data};
            if (st_q.cnt != CNT_W'(CNT_MAX)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_bits = st_q.sr;
    assign frame_end  = st_q.en_prev && !s_en;
    assign frame_ok   = frame_end && (st_q.cnt == CNT_W'(FRAME_LEN));

    // Counter restarts at each new frame (R10)
    assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_en && !st_q.en_prev) |=> (st_q.cnt == '0));
    // Count never passes its saturation value (R9)
    assert_count_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_W'(CNT_MAX)) |=> (st_q.cnt == CNT_W'(CNT_MAX) || st_q.cnt == '0));
endmodule

// File: rtl/a3w_latch.sv
module a3w_latch #(
    parameter int               ADDR_W    = 2,
    parameter int               CODE_W    = 14,
    parameter int               REF_W     = 2,
    parameter int               AUX_W     = 2,
    parameter int               FRAME_LEN = 21,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 2'b10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FRAME_LEN-1:0] frame_bits,
    input  logic                 frame_end,
    input  logic                 frame_ok,
    output logic [CODE_W-1:0]    code,
    output logic                 band,
    output logic [REF_W-1:0]     ref_sel,
    output logic [AUX_W-1:0]     aux
);
    localparam int CODE_TOP = FRAME_LEN - ADDR_W - 1;
    localparam int BAND_POS = REF_W + AUX_W;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              band;
        logic [REF_W-1:0]  ref_sel;
        logic [AUX_W-1:0]  aux;
    } fields_t;

    fields_t fld_d, fld_q;
    logic [ADDR_W-1:0] frame_addr;
    logic [AUX_W-1:0]  aux_in;
    logic              load;

    assign frame_addr = frame_bits[FRAME_LEN-1 -: ADDR_W];
    assign load       = frame_ok && (frame_addr == DEV_ADDR);

    for (genvar i = 0; i < AUX_W; i++) begin : g_aux
        assign aux_in[i] = frame_bits[AUX_W-1-i];
    end

    always_comb begin
        fld_d = fld_q;
        if (load) begin
            fld_d.code    = frame_bits[CODE_TOP -: CODE_W];
            fld_d.band    = frame_bits[BAND_POS];
            fld_d.ref_sel = frame_bits[AUX_W +: REF_W];
            fld_d.aux     = aux_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '0;
        else        fld_q <= fld_d;
    end

    assign code    = fld_q.code;
    assign band    = fld_q.band;
    assign ref_sel = fld_q.ref_sel;
    assign aux     = fld_q.aux;

    assert_hold_midframe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(fld_q));
    assert_hold_badlen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_ok) |=> $stable(fld_q));
    assert_hold_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && frame_addr != DEV_ADDR) |=> $stable(fld_q));
    assert_code_loaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && frame_addr == DEV_ADDR) |=> (fld_q.code == $past(frame_bits[CODE_TOP -: CODE_W])));
endmodule

// File: rtl/addr3w_ctrl_reg.sv
module addr3w_ctrl_reg #(
    parameter int                ADDR_W      = a3w_pkg::A3W_ADDR_W,
    parameter int                CODE_W      = a3w_pkg::A3W_CODE_W,
    parameter int                REF_W       = a3w_pkg::A3W_REF_W,
    parameter int                AUX_W       = a3w_pkg::A3W_AUX_W,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk,
    input  logic              bus_data,
    input  logic              bus_en,
    output logic [CODE_W-1:0] divide_code,
    output logic              fm_select,
    output logic [REF_W-1:0]  ref_select,
    output logic [AUX_W-1:0]  pull_dn_n
);
    import a3w_pkg::*;

    localparam int FRAME_LEN = ADDR_W + CODE_W + 1 + REF_W + AUX_W;

    logic [2:0]           bus_sync;
    logic [FRAME_LEN-1:0] frame_bits;
    logic                 frame_end, frame_ok;
    logic                 band;
    logic [AUX_W-1:0]     aux;

    a3w_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_en, bus_clk, bus_data}),
        .sync_out (bus_sync)
    );

    a3w_shifter #(.FRAME_LEN(FRAME_LEN)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_clk      (bus_sync[1]),
        .s_data     (bus_sync[0]),
        .s_en       (bus_sync[2]),
        .frame_bits (frame_bits),
        .frame_end  (frame_end),
        .frame_ok   (frame_ok)
    );

    a3w_latch #(
        .ADDR_W(ADDR_W), .CODE_W(CODE_W), .REF_W(REF_W), .AUX_W(AUX_W),
        .FRAME_LEN(FRAME_LEN), .DEV_ADDR(DEV_ADDR)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_bits (frame_bits),
        .frame_end  (frame_end),
        .frame_ok   (frame_ok),
        .code       (divide_code),
        .band       (band),
        .ref_sel    (ref_select),
        .aux        (aux)
    );

    assign fm_select = (band_e'(band) == BAND_FM);
    assign pull_dn_n = ~aux;

    // Latched outputs only change in the cycle after a frame end (R6)
    assert_out_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(pull_dn_n) && $stable(fm_select) && $stable(ref_select)));
endmodule

// File: tb/addr3w_ctrl_reg_test.sv
module addr3w_ctrl_reg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b0;
    logic [13:0] divide_code;
    logic        fm_select;
    logic [1:0]  ref_select, pull_dn_n;

    int checks = 0, errors = 0;
    logic [13:0] exp_code = '0;
    logic        exp_fm = 1'b0;
    logic [1:0]  exp_ref = '0, exp_pd = 2'b11;

    always #2 clk = ~clk;

    addr3w_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
        .bus_en(bus_en), .divide_code(divide_code), .fm_select(fm_select),
        .ref_select(ref_select), .pull_dn_n(pull_dn_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        chk({req, " divide_code"}, 32'(divide_code), 32'(exp_code));
        chk({req, " fm_select"},   32'(fm_select),   32'(exp_fm));
        chk({req, " ref_select"},  32'(ref_select),  32'(exp_ref));
        chk({req, " pull_dn_n"},   32'(pull_dn_n),   32'(exp_pd));
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nbits of vec, MSB first; optional mid-frame check after bit mid_at
    task automatic send_bits(input logic [31:0] vec, input int nbits, input int mid_at);
        bus_en = 1'b1;
        wait_sys(8);
        for (int i = nbits - 1; i >= 0; i--) begin
            bus_data = vec[i];
            wait_sys(8);
            bus_clk = 1'b1;
            wait_sys(8);
            bus_clk = 1'b0;
            if (nbits - i == mid_at) begin
                wait_sys(6);
                check_all("R6 mid-frame");
            end
        end
        wait_sys(8);
        bus_en = 1'b0;
        wait_sys(12);
    endtask

    function automatic logic [20:0] mk(input logic [1:0] a, input logic [13:0] n,
                                       input logic fm, input logic [1:0] r, input logic [1:0] ax);
        // ax[0] is sent first (frame bit 20), ax[1] last
        return {a, n, fm, r, ax[0], ax[1]};
    endfunction

    task automatic expect_load(input logic [13:0] n, input logic fm, input logic [1:0] r, input logic [1:0] ax);
        exp_code = n; exp_fm = fm; exp_ref = r; exp_pd = ~ax;
    endtask

    task automatic t_reset;
        check_all("R1 reset");
    endtask

    task automatic t_basic;
        send_bits(32'(mk(2'b10, 14'h2A5C, 1'b1, 2'b01, 2'b10)), 21, 0);
        expect_load(14'h2A5C, 1'b1, 2'b01, 2'b10);
        check_all("R2 R3 R4 R5 basic load");
    endtask

    task automatic t_patterns;
        send_bits(32'(mk(2'b10, 14'h3FFF, 1'b0, 2'b11, 2'b11)), 21, 0);
        expect_load(14'h3FFF, 1'b0, 2'b11, 2'b11);
        check_all("R2 R3 R4 R5 all ones");
        send_bits(32'(mk(2'b10, 14'h1555, 1'b1, 2'b10, 2'b01)), 21, 10);
        expect_load(14'h1555, 1'b1, 2'b10, 2'b01);
        check_all("R6 R11 alternating after mid-frame hold");
    endtask

    task automatic t_foreign;
        send_bits(32'(mk(2'b01, 14'h0123, 1'b0, 2'b00, 2'b11)), 21, 0);
        check_all("R7 foreign address");
        send_bits(32'(mk(2'b11, 14'h0456, 1'b0, 2'b01, 2'b00)), 21, 0);
        check_all("R7 foreign address 11");
    endtask

    task automatic t_lengths;
        logic [20:0] f;
        f = mk(2'b10, 14'h0777, 1'b0, 2'b00, 2'b00);
        send_bits(32'(f[20:1]), 20, 0);
        check_all("R8 short frame");
        send_bits(32'({f, 1'b0}), 22, 0);
        check_all("R9 long frame");
    endtask

    task automatic t_stray;
        for (int k = 0; k < 5; k++) begin
            bus_data = 1'b1;
            wait_sys(8);
            bus_clk = 1'b1;
            wait_sys(8);
            bus_clk = 1'b0;
        end
        check_all("R10 stray clocks with enable low");
        send_bits(32'(mk(2'b10, 14'h0001, 1'b0, 2'b00, 2'b00)), 21, 0);
        expect_load(14'h0001, 1'b0, 2'b00, 2'b00);
        check_all("R10 R11 frame after stray clocks");
    endtask

    initial begin
        wait_sys(4);
        rst_n = 1'b1;
        wait_sys(2);
        t_reset();
        t_basic();
        t_patterns();
        t_foreign();
        t_lengths();
        t_stray();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule